// File: doc/BRIEF.md
# Data-Strobe Line Encoder

This block turns a stream of parallel host words into a two-wire serial signal made of a Data line and a Strobe line. Every bit period exactly one of the two lines changes, so the receiver recovers a bit clock by taking the XOR of the two lines and needs no separate clock wire. The Data line carries the bit value. The Strobe line toggles only when the Data value repeats from one bit to the next.

The host offers a word with a valid/ready handshake. An accepted word is sent least-significant bit first. A clock-enable divider sets the bit period as a whole number of system clocks. The divider value is sampled while reset is held, so the link rate cannot change partway through a transfer. When no word is waiting, both lines hold their level and carry no edges. The ready output doubles as the idle indication.

Top module: `ds_serializer`

## Requirements
- R1: After each bit boundary, `ds_data` equals the value of the bit being sent: 1 drives it high and 0 drives it low.
- R2: At a bit boundary `ds_strobe` toggles if and only if the new bit equals the previous Data value.
- R3: At every bit boundary exactly one of `ds_data` and `ds_strobe` changes, so their XOR toggles once per bit.
- R4: The bits of an accepted word leave least-significant bit first, and bit 0 is the first bit sent.
- R5: The bit period P is the value of `div_cfg` sampled during reset, raised to 2 when that value is smaller than 2. The first bit appears on the line P clocks after the acceptance edge, and each later bit of the same word follows P clocks after the one before it.
- R6: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the edge that puts the last bit on the line. While `in_ready` is low, `in_valid` and `in_data` are ignored.
- R7: While reset is held and after it is released, both lines are low and `in_ready` is high. The first bit after reset applies R2 as though the previous Data value were 0.
- R8: While no word is in flight, `ds_data` and `ds_strobe` do not change.
- R9: Changes to `div_cfg` while reset is low do not change the bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; samples `div_cfg` |
| div_cfg | input | 16 | Bit period in system clocks, latched during reset |
| in_data | input | 8 | Host word to send |
| in_valid | input | 1 | Host word present |
| in_ready | output | 1 | Encoder can accept a word; high when idle |
| ds_data | output | 1 | Serial Data line |
| ds_strobe | output | 1 | Serial Strobe line |

## Verification
The hardest situation to reach is a host that keeps `in_valid` high with different data while a word is still being shifted out. The hazard is a word swapped in partway through, or a second acceptance that starts too early. The bench drives junk words with valid held high during most of each transfer. It drops valid just before the last bit and then checks that the decoded line stream still matches the original word. Divider values 0, 1, 2 and larger odd values cover the clamp. `div_cfg` is rewritten after reset to show that the bit spacing does not move.

// File: rtl/ds_pkg.sv
package ds_pkg;
  // one bit handed from the shifter to the line coder
  typedef struct packed {
    logic stb;  // bit boundary this cycle
    logic val;  // value of the bit
  } ds_bit_t;

  function automatic logic [15:0] clamp_period(input logic [15:0] d);
    return (d < 16'd2) ? 16'd2 : d;
  endfunction
endpackage

// File: rtl/ds_bit_timer.sv
module ds_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] period_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == period_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= (div_cfg < DIV_W'(2)) ? DIV_W'(2) : div_cfg;
      cnt_q    <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  p_period_floor_r5: assert property (@(posedge clk) disable iff (rst)
    period_q >= DIV_W'(2));
  p_rate_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    $stable(period_q));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period_q);
endmodule

// File: rtl/ds_word_shifter.sv
module ds_word_shifter
  import ds_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              tick,
  output logic              in_ready,
  output logic              busy,
  output ds_bit_t           bit_out
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;

  assign busy        = busy_q;
  assign in_ready    = !busy_q;
  assign bit_out.stb = tick;
  assign bit_out.val = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (in_valid && !busy_q) begin
      sh_q   <= in_data;
      left_q <= CNT_W'(WORD_W);
      busy_q <= 1'b1;
    end else if (tick) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  p_accept_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  p_tick_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
    tick |-> busy_q);
  p_left_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/ds_line_coder.sv
module ds_line_coder
  import ds_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ds_bit_t bit_in,
  output logic    ds_data,
  output logic    ds_strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ds_data   <= 1'b0;
      ds_strobe <= 1'b0;
    end else if (bit_in.stb) begin
      ds_data <= bit_in.val;
      if (bit_in.val == ds_data) ds_strobe <= ~ds_strobe;
    end
  end

  p_data_value_r1: assert property (@(posedge clk) disable iff (rst)
    bit_in.stb |=> (ds_data == $past(bit_in.val)));
  p_xor_toggles_r3: assert property (@(posedge clk) disable iff (rst)
    bit_in.stb |=> ((ds_data ^ ds_strobe) != $past(ds_data ^ ds_strobe)));
  p_one_line_r2: assert property (@(posedge clk) disable iff (rst)
    (ds_data != $past(ds_data)) |-> (ds_strobe == $past(ds_strobe)));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_in.stb |=> ($stable(ds_data) && $stable(ds_strobe)));
endmodule

// File: rtl/ds_serializer.sv
module ds_serializer
  import ds_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ds_data,
  output logic              ds_strobe
);
  logic    busy;
  logic    tick;
  ds_bit_t bit_w;

  ds_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .run(busy), .tick(tick)
  );

  ds_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .tick(tick), .in_ready(in_ready), .busy(busy), .bit_out(bit_w)
  );

  ds_line_coder u_coder (
    .clk(clk), .rst(rst), .bit_in(bit_w),
    .ds_data(ds_data), .ds_strobe(ds_strobe)
  );

  p_reset_low_r7: assert property (@(posedge clk)
    $past(rst) |-> (!ds_data && !ds_strobe && in_ready));
endmodule

// File: tb/tb_ds_serializer.sv
module tb_ds_serializer;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_cfg = 16'd0;
  logic [W-1:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, ds_data, ds_strobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic pd, ps;

  always #10 clk = ~clk;

  ds_serializer dut (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready),
    .ds_data(ds_data), .ds_strobe(ds_strobe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic do_reset(input int d);
    @(negedge clk);
    rst = 1'b1; div_cfg = 16'(d); in_valid = 1'b0;
    @(negedge clk);
    chk(ds_data == 0 && ds_strobe == 0, "R7 lines low in reset", {ds_data, ds_strobe}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ds_data == 0 && ds_strobe == 0, "R7 lines low after reset", {ds_data, ds_strobe}, 0);
    chk(in_ready == 1, "R7 ready after reset", in_ready, 1);
    pd = 1'b0; ps = 1'b0;
  endtask

  task automatic idle_check(input int n);
    int changes = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ds_data != pd || ds_strobe != ps) changes++;
    end
    chk(changes == 0, "R8 no edges while idle", changes, 0);
  endtask

  // sends one word and decodes the line; called at a negedge
  task automatic send_word(input logic [W-1:0] w, input int P, input bit junk);
    int c;
    logic eb;
    while (!in_ready) @(negedge clk);
    in_data = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 0, "R6 ready drops after accept", in_ready, 0);
    if (junk) begin in_valid = 1'b1; in_data = ~w ^ W'($urandom); end
    for (int i = 0; i < W; i++) begin
      c = 0;
      while (ds_data == pd && ds_strobe == ps && c < 4 * P + 4) begin
        @(negedge clk); c++;
      end
      eb = w[i];
      chk(c == P, "R5 bit spacing", c, P);
      chk((ds_data != pd) != (ds_strobe != ps), "R3 exactly one line changes",
          {ds_data != pd, ds_strobe != ps}, 1);
      chk(ds_data == eb, "R1 R4 data equals LSB-first bit", ds_data, eb);
      chk((ds_strobe != ps) == (eb == pd), "R2 R7 strobe toggles on repeat",
          ds_strobe != ps, eb == pd);
      pd = ds_data; ps = ds_strobe;
      if (junk && i == W - 2) in_valid = 1'b0;
      if (i < W - 1) chk(in_ready == 0, "R6 busy during word", in_ready, 0);
    end
    chk(in_ready == 1, "R6 ready after last bit", in_ready, 1);
  endtask

  initial begin
    int P;
    int divs[6] = '{0, 1, 2, 3, 5, 9};
    void'($urandom(32'd20240611));

    do_reset(0);
    P = period_of(0);
    send_word(8'h00, P, 1'b0);
    send_word(8'hFF, P, 1'b0);
    send_word(8'h55, P, 1'b0);
    idle_check(10);
    send_word(8'hA5, P, 1'b1);
    send_word(8'h3C, P, 1'b1);
    idle_check(6);

    foreach (divs[k]) begin
      do_reset(divs[k]);
      P = period_of(divs[k]);
      div_cfg = 16'(($urandom % 20) + 1); // R9: must not affect the period
      for (int n = 0; n < 12; n++) begin
        send_word(W'($urandom), P, 1'($urandom));
        if (($urandom % 3) == 0) idle_check(1 + ($urandom % (3 * P)));
      end
    end

    do_reset(13);
    P = 13;
    div_cfg = 16'd2; // R9
    send_word(8'h01, P, 1'b1);
    send_word(8'h80, P, 1'b0);
    idle_check(40);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule